// File: doc/BRIEF.md
# Dual-Port Byte-Lane Static RAM

This block is a true dual-port word memory, 8192 words of 16 bits by default. It has two ports, called left and right, and they are fully symmetric. Each port has its own active-low chip enable, read/write strobe (high means read), active-low output enable, a vector of active-low byte-lane selects, an address and a data path. Either port can read or write any word, one byte lane at a time or all lanes together.

The storage is synchronous and both ports share one clock. A read request is captured on a clock edge, and the data together with the per-lane drive flags is presented after that edge. The bidirectional data bus is split into a write-data input, a read-data output and a per-lane drive flag. A lane that is not driven reads as zero. The output enable gates the drive flags at once, without waiting for a clock edge.

When both ports write the same word in one cycle, the collision is resolved per lane: the left port takes a lane that both ports enable, and a lane enabled by only one port takes that port's data. A port that reads a word the other port is writing in the same cycle receives the word's previous contents. The word count, the data width and the lane width are parameters.

Top module: `dpr_sram`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits (8192 x 16 by default). Every word can be written and read back independently through either port.
- R2: A port whose chip enable `*_ce_n` is high writes nothing, and in the following cycle its drive flags are all zero.
- R3: A port whose lane selects are all high neither writes nor reads, and in the following cycle its drive flags are all zero.
- R4: With chip enable low and `*_rw_n` low, the port writes lane i (data bits [8i+7:8i]) only if `*_sel_n[i]` is low. Bit 1 of the select is the upper byte and bit 0 is the lower byte. A write never raises the port's drive flags.
- R5: With chip enable low, `*_rw_n` high and `*_oe_n` low, the port reads. In the next cycle `*_drv` equals the inverted select vector, and any lane that is not driven shows zero on `*_rdata`.
- R6: While `*_oe_n` is high, all drive flags of that port are zero, whatever the other controls are. A read request made with `*_oe_n` high returns nothing.
- R7: Read data and drive flags appear on the first clock edge after the read request and not before it. After reset, no lane is driven.
- R8: Both ports can read the same word in the same cycle, and each one receives the correct data.
- R9: When both ports write the same word in one cycle, each lane that both ports enable takes the left port's data, and each lane enabled by only one port takes that port's data.
- R10: A read of a word that the other port writes in the same cycle returns the word's contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low reset; clears the read-lane registers |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw_n | input | 1 | Left strobe: 1 = read, 0 = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_sel_n | input | DATA_W/LANE_W | Left lane selects, active low; bit 1 = upper byte |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data; undriven lanes read as zero |
| l_drv | output | DATA_W/LANE_W | Left per-lane drive flags |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw_n | input | 1 | Right strobe: 1 = read, 0 = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_sel_n | input | DATA_W/LANE_W | Right lane selects, active low; bit 1 = upper byte |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data; undriven lanes read as zero |
| r_drv | output | DATA_W/LANE_W | Right per-lane drive flags |

## Verification
A write takes effect at the edge that samples it. A read issued in cycle k is checked at the falling edge that follows edge k, and the bench also confirms that the drive flags are still low before that edge. Output-enable gating acts without a clock, so it is checked one nanosecond after the enable changes with no edge in between. Collisions and same-cycle read-during-write are checked on the cycle that carries them and then again by a later read of the affected word.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } port_op_e;
endpackage

// File: rtl/dpr_lane_bank.sv
// One byte lane of storage, with two write ports and two registered read ports.
module dpr_lane_bank #(
   parameter int ADDR_W = 13,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_we,
   input  logic              l_re,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [LANE_W-1:0] l_wd,
   input  logic              r_we,
   input  logic              r_re,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [LANE_W-1:0] r_wd,
   output logic [LANE_W-1:0] l_q,
   output logic [LANE_W-1:0] r_q
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] mem [DEPTH];

   // The right port is written first and the left port last, so when both
   // write the same word in this lane, the left port's data is kept.
   always_ff @(posedge clk) begin
      if (r_we) mem[r_addr] <= r_wd;
      if (l_we) mem[l_addr] <= l_wd;
   end

   // Reads sample the array before this edge's writes land, so they see the old word.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_q <= '0;
         r_q <= '0;
      end else begin
         if (l_re) l_q <= mem[l_addr];
         if (r_re) r_q <= mem[r_addr];
      end
   end

   // R8: two reads of one word in one cycle return the same lane data
   p_same_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (l_re && r_re && (l_addr == r_addr) && !l_we && !r_we) |=> (l_q == r_q));
endmodule

// File: rtl/dpr_port_ctrl.sv
// Decodes one port's controls and gates its registered read data.
module dpr_port_ctrl
   import dpr_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ce_n,
   input  logic                    rw_n,
   input  logic                    oe_n,
   input  logic [LANES-1:0]        sel_n,
   input  logic [LANES*LANE_W-1:0] bank_q,
   output logic [LANES-1:0]        wr_lane,
   output logic [LANES-1:0]        rd_lane,
   output logic [LANES-1:0]        drv,
   output logic [LANES*LANE_W-1:0] rdata
);
   port_op_e         op;
   logic [LANES-1:0] lane_q;

   always_comb begin
      if (ce_n || (&sel_n))  op = OP_IDLE;
      else if (!rw_n)        op = OP_WRITE;
      else if (!oe_n)        op = OP_READ;
      else                   op = OP_IDLE;
   end

   assign wr_lane = (op == OP_WRITE) ? ~sel_n : '0;
   assign rd_lane = (op == OP_READ)  ? ~sel_n : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= rd_lane;
   end

   // The output enable gates the lanes at once, with no clock edge involved.
   assign drv = lane_q & {LANES{~oe_n}};

   for (genvar g = 0; g < LANES; g++) begin : g_gate
      assign rdata[g*LANE_W +: LANE_W] = drv[g] ? bank_q[g*LANE_W +: LANE_W] : '0;
   end

   p_desel_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> (drv == '0));
   p_desel_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (&sel_n) |=> (drv == '0));
   p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rw_n) |=> (drv == '0));
   p_read_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && rw_n && !oe_n && !(&sel_n)) |=> (oe_n || (drv == ~$past(sel_n))));
endmodule

// File: rtl/dpr_sram.sv
module dpr_sram #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 16,
   parameter int LANE_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       l_ce_n,
   input  logic                       l_rw_n,
   input  logic                       l_oe_n,
   input  logic [DATA_W/LANE_W-1:0]   l_sel_n,
   input  logic [ADDR_W-1:0]          l_addr,
   input  logic [DATA_W-1:0]          l_wdata,
   output logic [DATA_W-1:0]          l_rdata,
   output logic [DATA_W/LANE_W-1:0]   l_drv,
   input  logic                       r_ce_n,
   input  logic                       r_rw_n,
   input  logic                       r_oe_n,
   input  logic [DATA_W/LANE_W-1:0]   r_sel_n,
   input  logic [ADDR_W-1:0]          r_addr,
   input  logic [DATA_W-1:0]          r_wdata,
   output logic [DATA_W-1:0]          r_rdata,
   output logic [DATA_W/LANE_W-1:0]   r_drv
);
   localparam int LANES = DATA_W / LANE_W;

   initial begin : elab_chk
      assert (LANE_W > 0 && DATA_W % LANE_W == 0)
         else $error("DATA_W must be a whole number of lanes");
      assert (ADDR_W > 0 && ADDR_W <= 16)
         else $error("ADDR_W out of range");
   end

   logic [LANES-1:0]  l_wr, l_rd, r_wr, r_rd;
   logic [DATA_W-1:0] l_bank_q, r_bank_q;

   dpr_port_ctrl #(.LANES(LANES), .LANE_W(LANE_W)) u_lctl (
      .clk(clk), .rst_n(rst_n), .ce_n(l_ce_n), .rw_n(l_rw_n), .oe_n(l_oe_n),
      .sel_n(l_sel_n), .bank_q(l_bank_q), .wr_lane(l_wr), .rd_lane(l_rd),
      .drv(l_drv), .rdata(l_rdata));

   dpr_port_ctrl #(.LANES(LANES), .LANE_W(LANE_W)) u_rctl (
      .clk(clk), .rst_n(rst_n), .ce_n(r_ce_n), .rw_n(r_rw_n), .oe_n(r_oe_n),
      .sel_n(r_sel_n), .bank_q(r_bank_q), .wr_lane(r_wr), .rd_lane(r_rd),
      .drv(r_drv), .rdata(r_rdata));

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      dpr_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .l_we(l_wr[g]), .l_re(l_rd[g]), .l_addr(l_addr),
         .l_wd(l_wdata[g*LANE_W +: LANE_W]),
         .r_we(r_wr[g]), .r_re(r_rd[g]), .r_addr(r_addr),
         .r_wd(r_wdata[g*LANE_W +: LANE_W]),
         .l_q(l_bank_q[g*LANE_W +: LANE_W]),
         .r_q(r_bank_q[g*LANE_W +: LANE_W]));
   end
endmodule

// File: tb/dpr_sram_tb_top.sv
module dpr_sram_tb_top;
   localparam int AW = 4;
   localparam int DW = 16;
   localparam int NW = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          l_ce_n, l_rw_n, l_oe_n, r_ce_n, r_rw_n, r_oe_n;
   logic [1:0]    l_sel_n, r_sel_n, l_drv, r_drv;
   logic [AW-1:0] l_addr, r_addr;
   logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 1'b0;
   logic [DW-1:0] mdl [NW];

   always #5 clk = ~clk;

   dpr_sram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_sel_n(l_sel_n),
      .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_drv(l_drv),
      .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_sel_n(r_sel_n),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_drv(r_drv));

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                           input logic [DW-1:0] d,
                                           input logic [1:0] sel);
      logic [DW-1:0] m;
      m = {{8{~sel[1]}}, {8{~sel[0]}}};
      return (old & ~m) | (d & m);
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic idle_all();
      l_ce_n = 1; l_rw_n = 1; l_oe_n = 1; l_sel_n = 2'b11; l_addr = '0; l_wdata = '0;
      r_ce_n = 1; r_rw_n = 1; r_oe_n = 1; r_sel_n = 2'b11; r_addr = '0; r_wdata = '0;
   endtask

   task automatic drive(input bit left, input logic ce, input logic rw,
                        input logic oe, input logic [1:0] sel,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
      if (left) begin
         l_ce_n = ce; l_rw_n = rw; l_oe_n = oe; l_sel_n = sel; l_addr = a; l_wdata = d;
      end else begin
         r_ce_n = ce; r_rw_n = rw; r_oe_n = oe; r_sel_n = sel; r_addr = a; r_wdata = d;
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input bit left, input logic [AW-1:0] a,
                     input logic [1:0] sel, input logic [DW-1:0] d);
      idle_all();
      drive(left, 1'b0, 1'b0, 1'b0, sel, a, d);
      tick();
      mdl[a] = merge(mdl[a], d, sel);
   endtask

   task automatic rd(input bit left, input logic [AW-1:0] a,
                     input logic [1:0] sel, input string req);
      logic [DW-1:0] exp_d;
      idle_all();
      drive(left, 1'b0, 1'b1, 1'b0, sel, a, '0);
      tick();
      exp_d = merge('0, mdl[a], sel);
      if (left) begin
         chk(req, "left drv", {14'd0, l_drv}, {14'd0, ~sel});
         chk(req, "left data", l_rdata, exp_d);
      end else begin
         chk(req, "right drv", {14'd0, r_drv}, {14'd0, ~sel});
         chk(req, "right data", r_rdata, exp_d);
      end
   endtask

   initial begin
      idle_all();
      repeat (3) tick();
      // R7: nothing is driven out of reset
      chk("R7", "reset left drv", {14'd0, l_drv}, '0);
      chk("R7", "reset right rdata", r_rdata, '0);
      rst_n = 1'b1;
      tick();

      // R1: fill through the left port and read every word through the right
      for (int a = 0; a < NW; a++) wr(1'b1, AW'(a), 2'b00, DW'(a * 16'h1111 ^ 16'hA5C3));
      for (int a = 0; a < NW; a++) rd(1'b0, AW'(a), 2'b00, "R1");
      // R1: refill through the right port and read through the left
      for (int a = 0; a < NW; a++) wr(1'b0, AW'(a), 2'b00, DW'(a * 16'h0707 + 16'h3C00));
      for (int a = 0; a < NW; a++) rd(1'b1, AW'(a), 2'b00, "R1");

      // R4: single-lane writes from both ports on every word
      for (int a = 0; a < NW; a++) begin
         wr(a[0], AW'(a), 2'b01, DW'(16'hE100 + a));   // upper lane only
         wr(!a[0], AW'(a), 2'b10, DW'(16'h00D2 + a * 256)); // lower lane only
         rd(a[1], AW'(a), 2'b00, "R4");
      end

      // R2: writes with chip enable high leave the word unchanged
      idle_all();
      drive(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 4'd6, 16'hDEAD);
      drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 4'd9, 16'hBEEF);
      tick();
      rd(1'b1, 4'd6, 2'b00, "R2");
      rd(1'b0, 4'd9, 2'b00, "R2");
      idle_all();
      drive(1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 4'd6, '0);
      tick();
      chk("R2", "deselected read drv", {14'd0, l_drv}, '0);

      // R3: all lane selects high: no write and no read
      idle_all();
      drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 4'd4, 16'h1234);
      tick();
      rd(1'b0, 4'd4, 2'b00, "R3");
      idle_all();
      drive(1'b0, 1'b0, 1'b1, 1'b0, 2'b11, 4'd4, '0);
      tick();
      chk("R3", "no-lane read drv", {14'd0, r_drv}, '0);
      chk("R3", "no-lane read data", r_rdata, '0);

      // R5: partial reads drive only the selected lane; the other reads zero
      for (int a = 0; a < NW; a += 5) begin
         rd(1'b1, AW'(a), 2'b01, "R5");
         rd(1'b0, AW'(a), 2'b10, "R5");
      end

      // R7: the read result is not visible before the capturing edge
      idle_all();
      tick();
      drive(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 4'd2, '0);
      #1;
      chk("R7", "drv before edge", {14'd0, l_drv}, '0);
      tick();
      chk("R7", "data after one edge", l_rdata, mdl[2]);

      // R6: output enable gates drive at once, and a read with it high returns nothing
      l_ce_n = 1'b1;
      l_oe_n = 1'b1;
      #1;
      chk("R6", "oe high drv", {14'd0, l_drv}, '0);
      chk("R6", "oe high data", l_rdata, '0);
      l_oe_n = 1'b0;
      #1;
      chk("R6", "oe low again drv", {14'd0, l_drv}, 16'h3);
      idle_all();
      drive(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 4'd2, '0);
      tick();
      r_oe_n = 1'b0;
      r_ce_n = 1'b1;
      #1;
      chk("R6", "read with oe high", {14'd0, r_drv}, '0);

      // R8: both ports read one word together
      idle_all();
      drive(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 4'd3, '0);
      drive(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 4'd3, '0);
      tick();
      chk("R8", "left data", l_rdata, mdl[3]);
      chk("R8", "right data", r_rdata, mdl[3]);

      // R9: same-word write collisions, lane by lane
      idle_all();
      drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 4'd5, 16'h1111);
      drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd5, 16'h2222);
      tick();
      mdl[5] = 16'h1111;
      rd(1'b0, 4'd5, 2'b00, "R9");
      idle_all();
      drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 4'd5, 16'hDDEE);
      drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd5, 16'hBBCC);
      tick();
      mdl[5] = 16'hBBEE;
      rd(1'b1, 4'd5, 2'b00, "R9");
      idle_all();
      drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 4'd5, 16'h7788);
      drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 4'd5, 16'h99AA);
      tick();
      mdl[5] = 16'h77AA;
      rd(1'b0, 4'd5, 2'b00, "R9");

      // R10: a read of a word being written by the other port sees the old word
      idle_all();
      drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 4'd7, 16'hC0DE);
      drive(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 4'd7, '0);
      tick();
      chk("R10", "right sees old", r_rdata, mdl[7]);
      mdl[7] = 16'hC0DE;
      idle_all();
      drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd8, 16'hF00D);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 4'd8, '0);
      tick();
      chk("R10", "left sees old", l_rdata, mdl[8]);
      mdl[8] = 16'hF00D;
      rd(1'b0, 4'd7, 2'b00, "R10");
      rd(1'b1, 4'd8, 2'b00, "R10");

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule